// File: doc/BRIEF.md
# Edge-Select Input Capture Unit

This block timestamps transitions on a set of external inputs. A free-running counter advances once every (prescale + 1) clock cycles while a global run bit is set. Each channel resynchronises its input, watches for the kind of transition that software has chosen for it, and on a match copies the counter into that channel's capture register and raises its pending flag.

The pending flags are gated by a mask register and combined into one interrupt line. Software reads the captured timestamps and clears flags by writing ones to an acknowledge register. Period and duty are derived in software from successive captures. Register access uses a single-cycle write strobe with a shared address, and a combinational read path.

Top module: `cap_unit`

## Requirements
- R1: After reset every readable register returns 0 and `irq` is low.
- R2: Each channel's transition selector is bits 1:0 of the register at 0x30 + 4*ch. It is encoded as 0 = never, 1 = low-to-high, 2 = high-to-low and 3 = either direction. A channel set to 0 never captures.
- R3: The control register at 0x50 holds the prescale value in bits 8:4 and the run bit in bit 10. While running, the counter increments once every (prescale + 1) clocks. While stopped, the counter holds and no channel captures.
- R4: The counter is CNT_W bits wide and wraps to 0 after its largest value.
- R5: A transition at the input sampled at clock edge k takes effect at edge k+2, after two synchroniser stages. At that edge the counter value held just before it is stored in the register at 0x10 + 4*ch.
- R6: A capture sets pending bit ch+1 of the status register at 0x58, whatever the mask says.
- R7: The mask register at 0x54 holds mask bit ch+1 for channel ch. `irq` is high exactly when some channel has both its pending bit and its mask bit set.
- R8: Writing the acknowledge register at 0x5C clears each pending bit whose data bit (bit ch+1) is 1. Bits written as 0 leave their pending bits alone.
- R9: When a capture and an acknowledge of the same channel meet on one clock edge, the pending bit ends up set.
- R10: Writes to the capture registers and to the status register change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| sig_in | input | NCH | Asynchronous inputs to be timestamped |
| irq | output | 1 | Masked OR of the pending flags |

## Verification
The hardest case to reach is an acknowledge that lands on the same edge as a new capture of that channel. The input change must be placed exactly two edges ahead of the write strobe. The bench toggles an input on a falling edge, waits two edges, and issues the acknowledge write so that it is sampled on the capture edge. Counter wrap is reached by building the bench with an 8-bit counter at prescale 0 and letting it run past 256 ticks before capturing. A behavioural model checks the interrupt line on every clock and checks the registers at each read.

// File: rtl/cap_pkg.sv
package cap_pkg;
   typedef enum logic [1:0] {
      EDGE_OFF  = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2,
      EDGE_ANY  = 2'd3
   } edge_sel_e;

   localparam int ADDR_CAP_BASE  = 'h10;
   localparam int ADDR_EDGE_BASE = 'h30;
   localparam int ADDR_CTRL      = 'h50;
   localparam int ADDR_IE        = 'h54;
   localparam int ADDR_STAT      = 'h58;
   localparam int ADDR_ACK       = 'h5C;
   localparam int REG_STRIDE     = 4;

   localparam int CTRL_PRE_LSB = 4;
   localparam int CTRL_RUN_BIT = 10;
   localparam int FLAG_LSB     = 1;
   localparam int MAX_CH       = 4;
endpackage

// File: rtl/cap_timebase.sv
module cap_timebase #(
   parameter int CNT_W = 32,
   parameter int PRE_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PRE_W-1:0] pre,
   output logic [CNT_W-1:0] cnt
);
   logic [PRE_W-1:0] div_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         cnt_q <= '0;
      end else if (!run) begin
         div_q <= '0;
      end else if (div_q == pre) begin
         div_q <= '0;
         cnt_q <= cnt_q + 1'b1;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/cap_channel.sv
module cap_channel
   import cap_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin,
   input  logic             run,
   input  edge_sel_e        code,
   input  logic [CNT_W-1:0] cnt,
   output logic             ev,
   output logic [CNT_W-1:0] cap
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   cur;
   logic                   hit;
   logic [CNT_W-1:0]       cap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign cur = sync_q[SYNC_STAGES-1];

   always_comb begin
      unique case (code)
         EDGE_RISE: hit = cur & ~prev_q;
         EDGE_FALL: hit = ~cur & prev_q;
         EDGE_ANY:  hit = cur ^ prev_q;
         default:   hit = 1'b0;
      endcase
   end

   assign ev = hit & run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cap_q <= '0;
      else if (ev) cap_q <= cnt;
   end

   assign cap = cap_q;
endmodule

// File: rtl/cap_unit.sv
module cap_unit
   import cap_pkg::*;
#(
   parameter int NCH         = 4,
   parameter int CNT_W       = 32,
   parameter int PRE_W       = 5,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NCH-1:0]    sig_in,
   output logic              irq
);
   generate
      if (NCH < 1 || NCH > MAX_CH) begin : g_bad_nch
         $error("cap_unit: NCH out of range");
      end
      if (CNT_W > DATA_W) begin : g_bad_cnt
         $error("cap_unit: CNT_W exceeds DATA_W");
      end
      if (PRE_W < 1 || PRE_W > CTRL_RUN_BIT - CTRL_PRE_LSB) begin : g_bad_pre
         $error("cap_unit: PRE_W overlaps the run bit");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("cap_unit: at least two synchroniser stages");
      end
   endgenerate

   logic [PRE_W-1:0] pre_q;
   logic             run_q;
   logic [NCH-1:0]   ie_q, stat_q, ev_w, ack_w;
   logic [CNT_W-1:0] cnt_w;
   logic [CNT_W-1:0] cap_w [NCH];
   edge_sel_e        code_q [NCH];
   logic [2*NCH-1:0] code_flat;
   logic             wr_ctrl, wr_ie, wr_ack;
   logic             unused_wdata;

   assign unused_wdata = ^bus_wdata;
   assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));
   assign wr_ie   = bus_wr && (bus_addr == ADDR_W'(ADDR_IE));
   assign wr_ack  = bus_wr && (bus_addr == ADDR_W'(ADDR_ACK));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         run_q <= 1'b0;
         ie_q  <= '0;
      end else begin
         if (wr_ctrl) begin
            pre_q <= bus_wdata[CTRL_PRE_LSB +: PRE_W];
            run_q <= bus_wdata[CTRL_RUN_BIT];
         end
         if (wr_ie) ie_q <= bus_wdata[FLAG_LSB +: NCH];
      end
   end

   cap_timebase #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .run(run_q), .pre(pre_q), .cnt(cnt_w)
   );

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         logic wr_edge;
         assign wr_edge = bus_wr &&
            (bus_addr == ADDR_W'(ADDR_EDGE_BASE + REG_STRIDE * i));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       code_q[i] <= EDGE_OFF;
            else if (wr_edge) code_q[i] <= edge_sel_e'(bus_wdata[1:0]);
         end
         assign code_flat[2*i +: 2] = code_q[i];

         cap_channel #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_ch (
            .clk(clk), .rst_n(rst_n), .pin(sig_in[i]), .run(run_q),
            .code(code_q[i]), .cnt(cnt_w), .ev(ev_w[i]), .cap(cap_w[i])
         );
      end
   endgenerate

   // a new capture outranks a simultaneous acknowledge
   assign ack_w = wr_ack ? bus_wdata[FLAG_LSB +: NCH] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~ack_w) | ev_w;
   end

   assign irq = |(stat_q & ie_q);

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(ADDR_CTRL)) begin
         bus_rdata[CTRL_PRE_LSB +: PRE_W] = pre_q;
         bus_rdata[CTRL_RUN_BIT]          = run_q;
      end
      if (bus_addr == ADDR_W'(ADDR_IE))   bus_rdata[FLAG_LSB +: NCH] = ie_q;
      if (bus_addr == ADDR_W'(ADDR_STAT)) bus_rdata[FLAG_LSB +: NCH] = stat_q;
      for (int i = 0; i < NCH; i++) begin
         if (bus_addr == ADDR_W'(ADDR_CAP_BASE + REG_STRIDE * i))
            bus_rdata[CNT_W-1:0] = cap_w[i];
         if (bus_addr == ADDR_W'(ADDR_EDGE_BASE + REG_STRIDE * i))
            bus_rdata[1:0] = code_q[i];
      end
   end
endmodule

// File: rtl/cap_unit_chk.sv
module cap_unit_chk #(
   parameter int NCH   = 4,
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic [CNT_W-1:0] cnt,
   input logic [NCH-1:0]   ev,
   input logic [NCH-1:0]   stat,
   input logic [NCH-1:0]   ie,
   input logic             irq,
   input logic [2*NCH-1:0] code_flat
);
   logic [NCH-1:0] active;
   always_comb
      for (int i = 0; i < NCH; i++) active[i] = |code_flat[2*i +: 2];

   // R2: a channel whose selector is 0 never produces a capture event
   a_r2_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (ev & ~active) == '0);

   // R3: stopped counter holds its value
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(cnt));

   // R3: no capture while stopped
   a_r3_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (ev == '0));

   // R4: the counter only ever moves forward by one, wrapping at the top
   a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != $past(cnt)) |-> (cnt == CNT_W'($past(cnt) + 1'b1)));

   // R6, R9: every capture leaves its pending bit set, acknowledge or not
   a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      (|ev) |=> ((stat & $past(ev)) == $past(ev)));

   // R7: nothing masked in means no interrupt
   a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (ie == '0) |-> !irq);
endmodule

bind cap_unit cap_unit_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run_q), .cnt(cnt_w), .ev(ev_w),
   .stat(stat_q), .ie(ie_q), .irq(irq), .code_flat(code_flat)
);

// File: tb/cap_unit_test.sv
`timescale 1ns/1ps
module cap_unit_test;
   localparam int NCH = 4;
   localparam int CW  = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  sig_in = '0;
   logic        irq;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   cap_unit #(.NCH(NCH), .CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sig_in(sig_in), .irq(irq)
   );

   // behavioural reference
   bit       m_s1 [4], m_s2 [4], m_s3 [4];
   int       m_code [4];
   int       m_cap [4];
   bit       m_run;
   int       m_pre, m_div, m_cnt;
   bit [3:0] m_stat, m_ie;

   always @(posedge clk) begin : mdl
      bit [3:0] ev;
      bit [3:0] clr;
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin
            m_s1[i] = 0; m_s2[i] = 0; m_s3[i] = 0; m_code[i] = 0; m_cap[i] = 0;
         end
         m_run = 0; m_pre = 0; m_div = 0; m_cnt = 0; m_stat = 0; m_ie = 0;
      end else begin
         for (int i = 0; i < 4; i++)
            ev[i] = m_run && ((m_code[i] == 1 && m_s2[i] && !m_s3[i]) ||
                              (m_code[i] == 2 && !m_s2[i] && m_s3[i]) ||
                              (m_code[i] == 3 && m_s2[i] != m_s3[i]));
         clr = (bus_wr && bus_addr == 8'h5C) ? bus_wdata[4:1] : 4'd0;
         for (int i = 0; i < 4; i++) if (ev[i]) m_cap[i] = m_cnt;
         m_stat = (m_stat & ~clr) | ev;
         if (m_run) begin
            if (m_div == m_pre) begin
               m_div = 0;
               m_cnt = (m_cnt + 1) % (1 << CW);
            end else m_div++;
         end else m_div = 0;
         for (int i = 0; i < 4; i++) begin
            m_s3[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = sig_in[i];
         end
         if (bus_wr) begin
            case (bus_addr)
               8'h50: begin m_pre = int'(bus_wdata[8:4]); m_run = bus_wdata[10]; end
               8'h54: m_ie = bus_wdata[4:1];
               8'h30, 8'h34, 8'h38, 8'h3C:
                  m_code[(bus_addr - 8'h30) / 4] = int'(bus_wdata[1:0]);
               default: ;
            endcase
         end
      end
   end

   function automatic int model_read(input logic [7:0] a);
      case (a)
         8'h50: return (int'(m_run) << 10) | (m_pre << 4);
         8'h54: return int'(m_ie) << 1;
         8'h58: return int'(m_stat) << 1;
         8'h10, 8'h14, 8'h18, 8'h1C: return m_cap[(a - 8'h10) / 4];
         8'h30, 8'h34, 8'h38, 8'h3C: return m_code[(a - 8'h30) / 4];
         default: return 0;
      endcase
   endfunction

   // R7: interrupt compared every clock
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (irq !== |(m_stat & m_ie)) begin
            errors++;
            $display("FAIL R7 irq actual %0b expected %0b", irq, |(m_stat & m_ie));
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input string tag);
      int exp;
      @(negedge clk);
      bus_addr = a;
      #1;
      exp = model_read(a);
      checks++;
      if (bus_rdata !== 32'(exp)) begin
         errors++;
         $display("FAIL %s addr %h actual %h expected %h", tag, a, bus_rdata, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         done = 1'b1;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(8'h50, "R1 ctrl"); rd(8'h54, "R1 mask"); rd(8'h58, "R1 status");
      for (int i = 0; i < 4; i++) begin
         rd(8'(8'h10 + 4*i), "R1 capture");
         rd(8'(8'h30 + 4*i), "R1 selector");
      end
      // R3 run, prescale 0; R2 selector codes
      wr(8'h50, 32'h400);
      wr(8'h30, 1); wr(8'h34, 2); wr(8'h38, 3); wr(8'h3C, 0);
      rd(8'h38, "R2 selector readback");
      idle(5);
      @(negedge clk) sig_in = 4'hF;
      idle(6);
      rd(8'h10, "R5 rising capture"); rd(8'h18, "R5 either capture");
      rd(8'h58, "R6 status without mask"); rd(8'h1C, "R2 disabled channel");
      wr(8'h54, 32'h1E);
      rd(8'h54, "R7 mask readback");
      @(negedge clk) sig_in = 4'h0;
      idle(6);
      rd(8'h14, "R5 falling capture"); rd(8'h58, "R6 status falling");
      // R8 selective clear
      wr(8'h5C, 32'h4);
      rd(8'h58, "R8 clear one");
      wr(8'h5C, 32'h1FF);
      rd(8'h58, "R8 clear all");
      // R10 read-only registers
      wr(8'h10, 32'hDEAD); wr(8'h58, 32'h1E);
      rd(8'h10, "R10 capture write ignored"); rd(8'h58, "R10 status write ignored");
      // R3 prescale 3
      wr(8'h50, 32'h430);
      @(negedge clk) sig_in[0] = 1'b1;
      idle(20);
      rd(8'h10, "R3 prescaled capture");
      @(negedge clk) sig_in[0] = 1'b0;
      idle(13);
      @(negedge clk) sig_in[0] = 1'b1;
      idle(6);
      rd(8'h10, "R3 prescaled second capture");
      wr(8'h5C, 32'h1FF);
      // R9 capture meets acknowledge on channel 2
      @(negedge clk) sig_in[2] = ~sig_in[2];
      @(negedge clk);
      @(negedge clk);
      bus_addr = 8'h5C; bus_wdata = 32'h1FF; bus_wr = 1'b1;
      @(negedge clk) bus_wr = 1'b0;
      rd(8'h58, "R9 capture wins over acknowledge");
      checks++;
      if (bus_rdata[3] !== 1'b1) begin
         errors++;
         $display("FAIL R9 status bit3 actual %0b expected 1", bus_rdata[3]);
      end
      wr(8'h5C, 32'h1FF);
      // R3 stopped: no captures, counter held
      wr(8'h50, 32'h0);
      @(negedge clk) sig_in = 4'hF;
      idle(10);
      rd(8'h58, "R3 stopped no status"); rd(8'h18, "R3 stopped no capture");
      // R4 wrap
      @(negedge clk) sig_in = 4'h0;
      idle(4);
      wr(8'h50, 32'h400);
      idle(300);
      @(negedge clk) sig_in[0] = 1'b1;
      idle(6);
      rd(8'h10, "R4 capture after wrap");
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule